// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block watches a set of comparator flags once per switching clock and decides when a switching regulator must shut down. It takes five fault flags: feedback too low, feedback too high, a current-limit hit in that cycle, a shorted high-side switch, and a hot die. Each flag has its own count of consecutive cycles that it must reach before it trips. Any trip sets one shared shutdown latch and records which sources caused it.

While the latch is set, the block controls the low-side switch to drain the output. It turns the switch on, turns it off once feedback has fallen below the lower drain flag, and turns it on again only when feedback rises above the upper flag. The block also drives an active-low power-good output from two window flags and a soft-start "fault arm" flag. A bias-supply lockout clears the latch. A rising edge on the enable input also clears it, except after an over-temperature trip, where the die must first report that it has cooled.

The controller is a three-state machine. ST_RUN means regulating with no fault. ST_DRAIN means latched with the low-side switch on. ST_PARK means latched with the low-side switch off. Its transitions are:
- TRIP: ST_RUN to ST_DRAIN, on any filter trip.
- DRAINED: ST_DRAIN to ST_PARK, on the low drain flag.
- RECHARGED: ST_PARK to ST_DRAIN, on the high drain flag.
- CLEAR: any state to ST_RUN, on a clear event.

Top module: `reg_fault_supervisor`

## Requirements
- R1: With `fault_arm` high, `fb_under` high for 16 consecutive clock edges sets `fault_latched` after the 16th edge, and not after the 15th.
- R2: While `fault_arm` is low, `fb_under` never sets the latch, and its cycle count is held at zero. After arming, a full 16 armed cycles are needed.
- R3: `fb_over` high for 2 consecutive edges sets the latch, whatever the level of `fault_arm`. A single cycle does not set it.
- R4: `ocp_hit` high for 16 consecutive edges sets the latch, whatever the level of `fault_arm`.
- R5: `hs_short` high at a single edge sets the latch at that edge.
- R6: `die_hot` at a single edge sets the latch. After an over-temperature trip, an enable rising edge clears the latch only if `die_cooled` was high at an earlier edge while latched.
- R7: `lowside_discharge_on` is high only while latched. It is high right after a trip, goes low after an edge with `fb_drained` high, and goes high again only after an edge with `fb_recharged` high.
- R8: `pgood_n` is low only when the block is not latched, `fault_arm` is high, and both `pg_low` and `pg_high` are low. It reflects the inputs sampled at the previous edge.
- R9: An edge with `bias_uvlo` high, or with `enable` high after an edge where it was low, clears the latch, the fault code and all cycle counts. Clear wins over a trip in the same edge.
- R10: `fault_code` bits are 0 = under-voltage, 1 = over-voltage, 2 = over-current, 3 = shorted high side, 4 = over-temperature. The code holds every source that tripped at the latching edge and does not change while the latch stays set.
- R11: Any edge at which a flag is low resets that source's count to zero, so 15 cycles, a gap, and 15 more cycles do not trip. Counts saturate rather than wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_uvlo | input | 1 | Bias supply below its lockout threshold |
| enable | input | 1 | Regulator enable level |
| fault_arm | input | 1 | Soft-start has reached the fault-enable point |
| fb_under | input | 1 | Feedback below the under-voltage threshold |
| fb_over | input | 1 | Feedback above 115% of reference |
| ocp_hit | input | 1 | Current limit reached in this cycle |
| hs_short | input | 1 | Switch node high while the low-side switch is fully on |
| die_hot | input | 1 | Die temperature above the trip point |
| die_cooled | input | 1 | Die temperature below the restart point |
| fb_drained | input | 1 | Feedback below the lower drain threshold |
| fb_recharged | input | 1 | Feedback above the upper drain threshold |
| pg_low | input | 1 | Feedback below the power-good window |
| pg_high | input | 1 | Feedback above the power-good window |
| fault_latched | output | 1 | Shutdown latch is set |
| fault_code | output | 5 | Sources that set the latch |
| lowside_discharge_on | output | 1 | Turn on the low-side switch to drain the output |
| pgood_n | output | 1 | Active-low power good |

## Verification
The assertions check properties that hold on every clock:
- the shorted-switch trip is immediate;
- the discharge drive never appears without the latch;
- power-good is never asserted while latched or before arming;
- a lockout always clears the latch and code;
- the code holds steady while latched;
- an under-voltage trip cannot occur unarmed.

Only the bench's scenarios can show the following:
- the exact 16- and 2-cycle filter lengths;
- the counts restarting after a gap;
- the drain hysteresis sequence;
- the cooled-die condition on re-enable;
- several sources being captured at the same edge.

The bench does this by comparing against a behavioural model on every clock.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int NUM_SRC = 5;
    localparam int SRC_UV  = 0;
    localparam int SRC_OV  = 1;
    localparam int SRC_OC  = 2;
    localparam int SRC_HS  = 3;
    localparam int SRC_OT  = 4;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_PARK  = 2'd2
    } sup_state_t;
endpackage

// File: rtl/rfs_filter.sv
module rfs_filter #(
    parameter int THRESH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flag,
    input  logic armed,
    output logic trip
);
    localparam int CW = $clog2(THRESH + 1);

    logic [CW-1:0] run_cnt;
    logic          live;

    assign live = flag && armed;

    // Trip on the edge that completes THRESH consecutive live cycles.
    assign trip = live && (run_cnt >= CW'(THRESH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr || !live) begin
            run_cnt <= '0;
        end else if (run_cnt != CW'(THRESH)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfs_ctrl.sv
module rfs_ctrl
    import rfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bias_uvlo,
    input  logic               enable,
    input  logic               fault_arm,
    input  logic [NUM_SRC-1:0] trips,
    input  logic               die_cooled,
    input  logic               fb_drained,
    input  logic               fb_recharged,
    input  logic               pg_low,
    input  logic               pg_high,
    output logic               clear_evt,
    output logic               fault_latched,
    output logic [NUM_SRC-1:0] fault_code,
    output logic               lowside_discharge_on,
    output logic               pgood_n
);
    sup_state_t state, state_nxt;
    logic       en_q;
    logic       cool_seen;
    logic       clear_ok;
    logic       any_trip;

    assign any_trip  = |trips;
    assign clear_ok  = !fault_code[SRC_OT] || cool_seen;
    assign clear_evt = bias_uvlo || (enable && !en_q && clear_ok);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:   if (!clear_evt && any_trip) state_nxt = ST_DRAIN;
            ST_DRAIN: if (clear_evt)              state_nxt = ST_RUN;
                      else if (fb_drained)        state_nxt = ST_PARK;
            ST_PARK:  if (clear_evt)              state_nxt = ST_RUN;
                      else if (fb_recharged)      state_nxt = ST_DRAIN;
            default:                              state_nxt = ST_RUN;
        endcase
    end

    // State register with its bookkeeping of cause and cooling.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            en_q       <= 1'b1;
            fault_code <= '0;
            cool_seen  <= 1'b0;
        end else begin
            state <= state_nxt;
            en_q  <= enable;
            if (clear_evt) begin
                fault_code <= '0;
                cool_seen  <= 1'b0;
            end else if (state == ST_RUN && any_trip) begin
                fault_code <= trips;
                cool_seen  <= 1'b0;
            end else if (state != ST_RUN && die_cooled) begin
                cool_seen <= 1'b1;
            end
        end
    end

    // Output register, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_latched        <= 1'b0;
            lowside_discharge_on <= 1'b0;
            pgood_n              <= 1'b1;
        end else begin
            fault_latched        <= (state_nxt != ST_RUN);
            lowside_discharge_on <= (state_nxt == ST_DRAIN);
            pgood_n              <= (state_nxt != ST_RUN) || !fault_arm || pg_low || pg_high;
        end
    end
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
    import rfs_pkg::*;
#(
    parameter int UV_CYCLES = 16,
    parameter int OV_CYCLES = 2,
    parameter int OC_CYCLES = 16,
    parameter int HS_CYCLES = 1,
    parameter int OT_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bias_uvlo,
    input  logic       enable,
    input  logic       fault_arm,
    input  logic       fb_under,
    input  logic       fb_over,
    input  logic       ocp_hit,
    input  logic       hs_short,
    input  logic       die_hot,
    input  logic       die_cooled,
    input  logic       fb_drained,
    input  logic       fb_recharged,
    input  logic       pg_low,
    input  logic       pg_high,
    output logic       fault_latched,
    output logic [4:0] fault_code,
    output logic       lowside_discharge_on,
    output logic       pgood_n
);
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] trips;
    logic               clear_evt;

    assign flags[SRC_UV] = fb_under;
    assign flags[SRC_OV] = fb_over;
    assign flags[SRC_OC] = ocp_hit;
    assign flags[SRC_HS] = hs_short;
    assign flags[SRC_OT] = die_hot;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int THR = (g == SRC_UV) ? UV_CYCLES :
                             (g == SRC_OV) ? OV_CYCLES :
                             (g == SRC_OC) ? OC_CYCLES :
                             (g == SRC_HS) ? HS_CYCLES : OT_CYCLES;
        logic armed;
        if (g == SRC_UV) begin : g_gated
            assign armed = fault_arm;
        end else begin : g_always
            assign armed = 1'b1;
        end
        rfs_filter #(.THRESH(THR)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear_evt),
            .flag  (flags[g]),
            .armed (armed),
            .trip  (trips[g])
        );
    end

    rfs_ctrl u_ctrl (
        .clk                  (clk),
        .rst_n                (rst_n),
        .bias_uvlo            (bias_uvlo),
        .enable               (enable),
        .fault_arm            (fault_arm),
        .trips                (trips),
        .die_cooled           (die_cooled),
        .fb_drained           (fb_drained),
        .fb_recharged         (fb_recharged),
        .pg_low               (pg_low),
        .pg_high              (pg_high),
        .clear_evt            (clear_evt),
        .fault_latched        (fault_latched),
        .fault_code           (fault_code),
        .lowside_discharge_on (lowside_discharge_on),
        .pgood_n              (pgood_n)
    );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bias_uvlo,
    input logic       enable,
    input logic       fault_arm,
    input logic       hs_short,
    input logic       fault_latched,
    input logic [4:0] fault_code,
    input logic       lowside_discharge_on,
    input logic       pgood_n
);
    assert_uv_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_latched) && fault_code[0]) |-> $past(fault_arm));

    assert_hs_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_short && !fault_latched && !bias_uvlo && !(enable && !$past(enable)))
        |=> fault_latched);

    assert_drain_only_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lowside_discharge_on |-> fault_latched);

    assert_pgood_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_n |-> (!fault_latched && $past(fault_arm)));

    assert_uvlo_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bias_uvlo |=> (!fault_latched && fault_code == 5'd0));

    assert_code_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_latched) |-> (fault_code != 5'd0));

    assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && $past(fault_latched)) |-> $stable(fault_code));
endmodule

bind reg_fault_supervisor rfs_checker u_rfs_checker (
    .clk                  (clk),
    .rst_n                (rst_n),
    .bias_uvlo            (bias_uvlo),
    .enable               (enable),
    .fault_arm            (fault_arm),
    .hs_short             (hs_short),
    .fault_latched        (fault_latched),
    .fault_code           (fault_code),
    .lowside_discharge_on (lowside_discharge_on),
    .pgood_n              (pgood_n)
);

// File: tb/test_reg_fault_supervisor.sv
module test_reg_fault_supervisor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bias_uvlo = 0, enable = 1, fault_arm = 0;
    logic fb_under = 0, fb_over = 0, ocp_hit = 0, hs_short = 0, die_hot = 0;
    logic die_cooled = 0, fb_drained = 0, fb_recharged = 0, pg_low = 0, pg_high = 0;
    logic       fault_latched, lowside_discharge_on, pgood_n;
    logic [4:0] fault_code;

    int    n_checks = 0, n_fail = 0;
    bit    done = 0;
    string cur_req = "R9";

    always #4 clk = ~clk;

    reg_fault_supervisor i_reg_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .bias_uvlo(bias_uvlo), .enable(enable),
        .fault_arm(fault_arm), .fb_under(fb_under), .fb_over(fb_over),
        .ocp_hit(ocp_hit), .hs_short(hs_short), .die_hot(die_hot),
        .die_cooled(die_cooled), .fb_drained(fb_drained), .fb_recharged(fb_recharged),
        .pg_low(pg_low), .pg_high(pg_high), .fault_latched(fault_latched),
        .fault_code(fault_code), .lowside_discharge_on(lowside_discharge_on),
        .pgood_n(pgood_n));

    // Behavioural reference: mode 0 = running, 1 = draining, 2 = parked.
    int   m_cnt[5];
    int   m_thr[5] = '{16, 2, 16, 1, 1};
    int   m_mode = 0;
    bit   m_enp = 1, m_cool = 0, m_lat = 0, m_ls = 0, m_pgn = 1;
    logic [4:0] m_code = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_mode = 0; m_enp = 1; m_cool = 0; m_code = 0;
            m_lat = 0; m_ls = 0; m_pgn = 1;
        end else begin
            logic [4:0] f, hit;
            bit clr;
            f   = {die_hot, hs_short, ocp_hit, fb_over, fb_under};
            clr = bias_uvlo || (enable && !m_enp && (!m_code[4] || m_cool));
            for (int i = 0; i < 5; i++) begin
                bit live;
                live   = f[i] && (i != 0 || fault_arm);
                hit[i] = live && (m_cnt[i] + 1 >= m_thr[i]);
                if (clr || !live) m_cnt[i] = 0;
                else if (m_cnt[i] < m_thr[i]) m_cnt[i]++;
            end
            if (clr) begin
                m_mode = 0; m_code = 0; m_cool = 0;
            end else if (m_mode == 0) begin
                if (hit != 0) begin m_mode = 1; m_code = hit; m_cool = 0; end
            end else begin
                if (die_cooled) m_cool = 1;
                if (m_mode == 1 && fb_drained) m_mode = 2;
                else if (m_mode == 2 && fb_recharged) m_mode = 1;
            end
            m_enp = enable;
            m_lat = (m_mode != 0);
            m_ls  = (m_mode == 1);
            m_pgn = (m_mode != 0) || !fault_arm || pg_low || pg_high;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if ({fault_latched, lowside_discharge_on, pgood_n, fault_code} !==
                {m_lat, m_ls, m_pgn, m_code}) begin
                n_fail++;
                $display("FAIL %s model: got lat=%0b ls=%0b pgn=%0b code=%05b exp lat=%0b ls=%0b pgn=%0b code=%05b",
                         cur_req, fault_latched, lowside_discharge_on, pgood_n, fault_code,
                         m_lat, m_ls, m_pgn, m_code);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic expect_v(string req, logic [7:0] got, logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic uvlo_clear();
        bias_uvlo = 1; tick(); bias_uvlo = 0; tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(2);
        rst_n = 1;
        tick();
        // R9 reset state
        expect_v("R9", {fault_latched, lowside_discharge_on, pgood_n, fault_code},
                 {1'b0, 1'b0, 1'b1, 5'd0});

        // R2: under-voltage ignored before arming
        cur_req = "R2"; fb_under = 1; tick(20);
        expect_v("R2", fault_latched, 0);
        // R1: 16 armed cycles
        cur_req = "R1"; fault_arm = 1; tick(15);
        expect_v("R1", fault_latched, 0);
        tick();
        expect_v("R1", fault_latched, 1);
        expect_v("R10", fault_code, 5'b00001);
        fb_under = 0;
        expect_v("R7", lowside_discharge_on, 1);

        // R7 discharge hysteresis
        cur_req = "R7"; fb_drained = 1; tick(); fb_drained = 0;
        expect_v("R7", lowside_discharge_on, 0);
        tick(3);
        expect_v("R7", lowside_discharge_on, 0);
        fb_recharged = 1; tick(); fb_recharged = 0;
        expect_v("R7", lowside_discharge_on, 1);

        // R9 enable toggle clear
        cur_req = "R9"; enable = 0; tick();
        expect_v("R9", fault_latched, 1);
        enable = 1; tick();
        expect_v("R9", {fault_latched, fault_code}, 0);

        // R11 gap restarts count
        cur_req = "R11"; fb_under = 1; tick(15); fb_under = 0; tick(); fb_under = 1; tick(15);
        fb_under = 0; tick();
        expect_v("R11", fault_latched, 0);

        // R3 over-voltage during soft-start
        cur_req = "R3"; fault_arm = 0;
        fb_over = 1; tick(); fb_over = 0; tick();
        expect_v("R3", fault_latched, 0);
        fb_over = 1; tick(2); fb_over = 0;
        expect_v("R3", {fault_latched, fault_code}, {1'b1, 5'b00010});
        cur_req = "R9"; uvlo_clear();
        expect_v("R9", {fault_latched, fault_code}, 0);

        // R4 over-current during soft-start
        cur_req = "R4"; ocp_hit = 1; tick(15);
        expect_v("R4", fault_latched, 0);
        tick(); ocp_hit = 0;
        expect_v("R4", {fault_latched, fault_code}, {1'b1, 5'b00100});
        uvlo_clear();

        // R5 shorted high side
        cur_req = "R5"; hs_short = 1; tick(); hs_short = 0;
        expect_v("R5", {fault_latched, fault_code}, {1'b1, 5'b01000});
        uvlo_clear();

        // R6 over-temperature needs cooling before re-enable
        cur_req = "R6"; die_hot = 1; tick(); die_hot = 0;
        expect_v("R6", {fault_latched, fault_code}, {1'b1, 5'b10000});
        enable = 0; tick(); enable = 1; tick();
        expect_v("R6", fault_latched, 1);
        die_cooled = 1; tick(); die_cooled = 0;
        enable = 0; tick(); enable = 1; tick();
        expect_v("R6", fault_latched, 0);

        // R10 simultaneous capture, then later trips ignored
        cur_req = "R10"; hs_short = 1; die_hot = 1; tick(); hs_short = 0; die_hot = 0;
        expect_v("R10", fault_code, 5'b11000);
        fb_over = 1; tick(3); fb_over = 0;
        expect_v("R10", fault_code, 5'b11000);
        uvlo_clear();

        // R8 power-good window
        cur_req = "R8"; fault_arm = 1; tick();
        expect_v("R8", pgood_n, 0);
        pg_high = 1; tick(); pg_high = 0;
        expect_v("R8", pgood_n, 1);
        pg_low = 1; tick(); pg_low = 0;
        expect_v("R8", pgood_n, 1);
        tick();
        expect_v("R8", pgood_n, 0);
        fault_arm = 0; tick();
        expect_v("R8", pgood_n, 1);

        tick(2);
        finish_run();
    end
endmodule